// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running calendar and raises an alarm when the calendar reaches a programmed moment. It holds six byte-wide alarm registers, one for each calendar field: seconds, minutes, hours, day of week, day of month and month. Each register has its own compare enable. Fields whose enable is clear are excluded from the match, so software can ask for an alarm at "minute 30 of every hour" or "the 12th month, any day".

On every clock the enabled fields are compared with the live calendar bytes. The first cycle on which all enabled fields agree sets a sticky alarm flag in a control register. An interrupt enable bit in the same register gates the flag onto the interrupt output. Software clears the flag by writing the control register. The usual sequence is to clear the flag and the enable first, then program the fields, then set the enable again.

Top module: `bcd_alarm_match`

## Requirements
- R1: Alarm field registers sit at addresses 0 to 5 in this order: seconds, minutes, hours, weekday, day, month. A write stores the whole byte, and a read at the same address returns it unchanged.
- R2: In a field register, bit 7 is the compare enable and bits 6:0 hold the BCD target. An enabled field matches when the calendar byte for that field, taken from cal_now[8i+7:8i] for register i, equals the target with bit 7 at 0.
- R3: A field whose enable bit is 0 takes no part in the match, whatever its target bits and whatever its calendar byte.
- R4: While no field is enabled the alarm flag is never set, even when every calendar byte equals every stored target.
- R5: The alarm flag is set on the clock edge at which the match condition goes from false to true. It then stays set until software clears it. A match that persists does not set the flag again after a clear; the match must first drop and then return.
- R6: The flag sets whether the interrupt enable is on or off. irq is high exactly when both the flag and the interrupt enable are 1.
- R7: The control register is at address 6. Bit 3 is the interrupt enable, bit 0 is the alarm flag, and all other bits read 0. Writing it loads bit 3. A write with bit 0 at 0 clears the flag. A write with bit 0 at 1 leaves the flag unchanged and never sets it.
- R8: If a match rising edge and a flag-clearing write fall on the same clock edge, the flag ends up set.
- R9: The month field compares BCD month values 01 to 12. The alarm fires on a two-digit month such as 0x12 only when all other enabled fields match as well.
- R10: After a synchronous reset, all field registers read 0x00, the control register reads 0x00 and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Register address for reads and writes |
| wdata | input | 8 | Write data |
| cal_now | input | NUM_FIELDS*8 (48) | Live calendar bytes in BCD, field i in bits 8i+7:8i |
| rdata | output | 8 | Combinational read data for addr |
| irq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach is a flag-clearing write that lands on the same edge as a fresh match rising edge. To get there, the bench first sets the flag with a match and then moves the calendar off the target. In one cycle it then drives the clear write and the matching calendar byte together. The second hard case is a match that persists after a clear. The bench holds the calendar on target across the clear to show that the flag stays down, then steps the calendar away and back to re-arm it. A behavioural model of flag, enable and field state checks irq on every clock throughout.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int ALM_FIELDS = 6;
    localparam int BYTE_W     = 8;
    localparam int EN_BIT     = 7;
    localparam int AIE_BIT    = 3;
    localparam int FLAG_BIT   = 0;

    typedef struct packed {
        logic       en;
        logic [6:0] target;
    } alm_field_t;

    // A field that is switched off never blocks the match.
    function automatic logic field_hit(alm_field_t f, logic [BYTE_W-1:0] cal);
        return !f.en || ({1'b0, f.target} == cal);
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_image(logic aie, logic flag);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[AIE_BIT]  = aie;
        v[FLAG_BIT] = flag;
        return v;
    endfunction

endpackage

// File: rtl/alm_field.sv
module alm_field #(
    parameter int IDX    = 0,
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [alm_pkg::BYTE_W-1:0] wdata,
    input  logic [alm_pkg::BYTE_W-1:0] cal_byte,
    output alm_pkg::alm_field_t       cfg,
    output logic                      hit,
    output logic                      enabled
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

    alm_pkg::alm_field_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en && addr == MY_ADDR) begin
            cfg_q <= alm_pkg::alm_field_t'(wdata);
        end
    end

    assign cfg     = cfg_q;
    assign enabled = cfg_q.en;
    assign hit     = alm_pkg::field_hit(cfg_q, cal_byte);

endmodule

// File: rtl/alm_flag_ctrl.sv
module alm_flag_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wr_aie_bit,
    input  logic wr_flag_bit,
    input  logic match,
    output logic flag,
    output logic aie
);
    logic match_q;
    logic rise;

    assign rise = match && !match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
            flag    <= 1'b0;
            aie     <= 1'b0;
        end else begin
            match_q <= match;
            if (ctrl_wr) begin
                aie <= wr_aie_bit;
            end
            // A new match event outranks a software clear.
            if (rise) begin
                flag <= 1'b1;
            end else if (ctrl_wr && !wr_flag_bit) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match #(
    parameter int NUM_FIELDS = alm_pkg::ALM_FIELDS,
    parameter int ADDR_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    input  logic [NUM_FIELDS*8-1:0] cal_now,
    output logic [7:0]             rdata,
    output logic                   irq
);
    localparam int                CTRL_IDX  = NUM_FIELDS;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_IDX);

    alm_pkg::alm_field_t    cfg [NUM_FIELDS];
    logic [NUM_FIELDS-1:0]  hits;
    logic [NUM_FIELDS-1:0]  ens;
    logic                   any_en;
    logic                   all_match;
    logic                   ctrl_wr;
    logic                   flag_q;
    logic                   aie_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        alm_field #(
            .IDX    (g),
            .ADDR_W (ADDR_W)
        ) u_field (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .addr     (addr),
            .wdata    (wdata),
            .cal_byte (cal_now[g*8 +: 8]),
            .cfg      (cfg[g]),
            .hit      (hits[g]),
            .enabled  (ens[g])
        );
    end

    assign any_en    = |ens;
    assign all_match = any_en && (&hits);
    assign ctrl_wr   = wr_en && (addr == CTRL_ADDR);

    alm_flag_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .wr_aie_bit  (wdata[alm_pkg::AIE_BIT]),
        .wr_flag_bit (wdata[alm_pkg::FLAG_BIT]),
        .match       (all_match),
        .flag        (flag_q),
        .aie         (aie_q)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = cfg[i];
            end
        end
        if (addr == CTRL_ADDR) begin
            rdata = alm_pkg::ctrl_image(aie_q, flag_q);
        end
    end

    assign irq = flag_q && aie_q;

endmodule

// File: rtl/alarm_chk.sv
module alarm_chk #(
    parameter int ADDR_W    = 3,
    parameter int CTRL_ADDR = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_flag_bit,
    input logic              irq,
    input logic              all_match,
    input logic              any_en,
    input logic              flag_q
);
    logic clear_wr;
    assign clear_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR)) && !wr_flag_bit;

    // R4
    no_enable_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_en && !flag_q) |=> !flag_q);

    // R5
    flag_rise_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(all_match));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clear_wr) |=> flag_q);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!flag_q && !irq));

endmodule

bind bcd_alarm_match alarm_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_IDX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_flag_bit (wdata[0]),
    .irq         (irq),
    .all_match   (all_match),
    .any_en      (any_en),
    .flag_q      (flag_q)
);

// File: tb/bcd_alarm_match_tb.sv
module bcd_alarm_match_tb;
    localparam int NF = 6;
    localparam int AW = 3;

    logic          clk = 0;
    logic          rst = 1;
    logic          wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    cal_b [NF];
    logic [NF*8-1:0] cal_now;
    logic [7:0]    rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign cal_now = {cal_b[5], cal_b[4], cal_b[3], cal_b[2], cal_b[1], cal_b[0]};

    bcd_alarm_match #(.NUM_FIELDS(NF), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cal_now(cal_now), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference for the interrupt line
    logic [7:0] m_reg [NF];
    bit m_flag, m_aie, m_prev;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_reg[k]) m_reg[k] = 8'h00;
            m_flag = 0; m_aie = 0; m_prev = 0;
        end else begin
            bit any, ok, now;
            any = 0; ok = 1;
            for (int k = 0; k < NF; k++) begin
                if (m_reg[k][7]) begin
                    any = 1;
                    if (cal_b[k] != {1'b0, m_reg[k][6:0]}) ok = 0;
                end
            end
            now = any && ok;
            if (now && !m_prev) m_flag = 1;
            else if (wr_en && addr == 3'd6 && !wdata[0]) m_flag = 0;
            if (wr_en && addr == 3'd6) m_aie = wdata[3];
            if (wr_en && addr < 3'd6) m_reg[addr] = wdata;
            m_prev = now;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            checks++;
            if (irq !== (m_flag && m_aie)) begin
                errors++;
                $display("FAIL R6 model irq actual %0b expected %0b", irq, m_flag && m_aie);
            end
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1; addr = AW'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk);
        addr = AW'(a);
        #1;
        chk(tag, int'(rdata), exp);
    endtask

    task automatic setcal(int f, int v);
        @(negedge clk);
        cal_b[f] = 8'(v);
    endtask

    initial begin
        cal_b[0] = 8'h00; cal_b[1] = 8'h00; cal_b[2] = 8'h00;
        cal_b[3] = 8'h00; cal_b[4] = 8'h01; cal_b[5] = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R10 reset state
        for (int a = 0; a < 7; a++) rd(a, 0, "R10 reset value");
        chk("R10 irq after reset", int'(irq), 0);

        // R1 storage and read back
        wr(0, 8'hB0);
        rd(0, 8'hB0, "R1 seconds readback");
        wr(1, 8'h15);
        rd(1, 8'h15, "R1 minutes readback");

        // R2 match on seconds; R3 minutes field disabled with a different byte
        setcal(1, 8'h44);
        setcal(0, 8'h30);
        rd(6, 8'h01, "R2 R3 flag set on seconds match");
        chk("R6 flag sets with enable off, irq low", int'(irq), 0);

        // R7 bit0=1 keeps flag, loads enable
        wr(6, 8'h09);
        rd(6, 8'h09, "R7 write with bit0 set keeps flag");
        chk("R6 irq with flag and enable", int'(irq), 1);

        // R7 clear; R5 persisting match does not re-set
        wr(6, 8'h08);
        rd(6, 8'h08, "R7 clear flag");
        repeat (3) @(negedge clk);
        rd(6, 8'h08, "R5 no re-set while match persists");

        // R5 re-arm after the match drops
        setcal(0, 8'h31);
        rd(6, 8'h08, "R5 flag stays clear off target");
        setcal(0, 8'h30);
        rd(6, 8'h09, "R5 flag set on new match edge");

        // R9 month and hour together
        wr(6, 8'h08);
        wr(0, 8'h00);
        wr(2, 8'hA3);
        wr(5, 8'h92);
        setcal(2, 8'h23);
        setcal(5, 8'h11);
        rd(6, 8'h08, "R9 month 11 does not match 12");
        setcal(5, 8'h12);
        rd(6, 8'h09, "R9 month 12 with hour 23 matches");
        wr(6, 8'h08);
        setcal(5, 8'h01);
        setcal(2, 8'h22);
        setcal(5, 8'h12);
        rd(6, 8'h08, "R9 hour mismatch blocks month match");

        // R4 nothing enabled, all bytes equal stored targets (zero)
        wr(2, 8'h00);
        wr(5, 8'h00);
        wr(1, 8'h00);
        wr(6, 8'h08);
        for (int f = 0; f < NF; f++) setcal(f, 8'h00);
        repeat (4) @(negedge clk);
        rd(6, 8'h08, "R4 all-disabled never fires");
        chk("R4 irq low", int'(irq), 0);

        // R8 set and clear on the same edge
        wr(0, 8'h85);
        setcal(0, 8'h05);
        rd(6, 8'h09, "R8 setup flag set");
        setcal(0, 8'h04);
        @(negedge clk);
        wr_en = 1; addr = 3'd6; wdata = 8'h08; cal_b[0] = 8'h05;
        @(negedge clk);
        wr_en = 0;
        rd(6, 8'h09, "R8 new match outranks clear");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule